// File: doc/BRIEF.md
# Skip-Group Condition Evaluator

This block decides whether an 18-bit processor skips its next instruction when it executes a conditional-skip group instruction. When the strobe is high, the block reads the instruction word along with the accumulator, the IO register, the overflow flag, six sense switches and six program flags. One clock later it presents a one-cycle skip decision. The program counter logic uses that decision to advance one extra word. In the same cycle the block can also present a pulse that tells the overflow flag to clear.

Each condition is enabled by its own bit in the low twelve bits of the instruction, and several may be set in one word. The enabled tests are ORed together. The lowest opcode bit then inverts the ORed result, which turns "skip if any test holds" into "skip if none holds". Sense switches and program flags are not selected by single bits. Each has a 3-bit field that names one line, or all six lines together, or no line at all. The whole evaluation finishes in one cycle, however many tests are combined.

Top module: `skip_eval`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `skip` and `ovf_clr` are low.
- R2: Only a strobed word whose top five bits are 11010 (opcode 64 or 65 octal, instr[17:13]) produces output. A strobed word with any other opcode, or no strobe, leaves `skip` and `ovf_clr` low in the next cycle.
- R3: Mask bit 6 (octal 0100) tests that the AC is all zeros.
- R4: Mask bit 7 (octal 0200) tests that the AC sign bit (bit 17) is clear, and mask bit 8 (octal 0400) tests that it is set. An all-ones AC (minus zero) therefore counts as negative and as non-zero.
- R5: Mask bit 9 (octal 1000) tests that the overflow flag is clear.
- R6: Mask bit 10 (octal 2000) tests that the IO sign bit (bit 17) is clear. Mask bit 11 has no effect.
- R7: The sense field instr[5:3] works as follows. Value 0 means no test. Values 1 to 6 test that switch `sense_sw[n-1]` is 0. Value 7 tests that all six switches are 0.
- R8: The flag field instr[2:0] uses the same coding as R7, applied to `flags`.
- R9: All enabled tests from R3 to R8 are ORed together.
- R10: Opcode bit instr[12] (opcode 65) inverts the ORed result after the OR. A word with no test enabled therefore never skips under opcode 64 and always skips under opcode 65.
- R11: `ovf_clr` pulses in the same cycle as the skip decision whenever a strobed group word has mask bit 9 set, for either opcode.
- R12: Both outputs appear exactly one clock after the strobed cycle and last one cycle unless the next cycle is strobed too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | Evaluate the instruction word in this cycle |
| instr | input | 18 | Instruction word |
| acc | input | 18 | Accumulator contents |
| ioreg | input | 18 | IO register contents |
| ovf | input | 1 | Overflow flag |
| sense_sw | input | 6 | Sense switch lines |
| flags | input | 6 | Program flag lines |
| skip | output | 1 | Skip the next instruction |
| ovf_clr | output | 1 | Clear-overflow pulse |

## Verification
A wrong internal state shows up at the ports exactly one clock after the strobe. There it appears either as a skip decision with the wrong polarity or as a missing or spurious overflow-clear pulse. There is no state that lasts beyond one cycle. A fault in field decoding, sign handling or OR combination is therefore visible in the first cycle after the faulty word. The sweeps cover every mask combination against the AC, IO and overflow patterns, and every field code against every pattern on the switch and flag lines. This exposes any decode error at the evaluation that triggers it.

// File: rtl/skp_pkg.sv
package skp_pkg;
  localparam int WORD_W = 18;
  localparam int NSEL   = 6;
  localparam int SEL_W  = 3;

  // Opcode prefix shared by both members of the skip group (top five bits)
  localparam logic [4:0] GRP_PREFIX = 5'b11010;

  typedef struct packed {
    logic             grp;     // word belongs to the skip group
    logic             inv;     // inverted sense
    logic             t_az;    // AC zero
    logic             t_ap;    // AC sign clear
    logic             t_an;    // AC sign set
    logic             t_oc;    // overflow clear
    logic             t_ip;    // IO sign clear
    logic [SEL_W-1:0] sw_code;
    logic [SEL_W-1:0] fl_code;
  } skp_dec_t;

  function automatic logic word_is_zero(input logic [WORD_W-1:0] w);
    return (w == '0);
  endfunction

  function automatic logic word_sign(input logic [WORD_W-1:0] w);
    return w[WORD_W-1];
  endfunction
endpackage

// File: rtl/skp_decode.sv
module skp_decode
  import skp_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  output skp_dec_t          dec
);
  always_comb begin
    dec.grp     = (instr[WORD_W-1:WORD_W-5] == GRP_PREFIX);
    dec.inv     = instr[12];
    dec.t_az    = instr[6];
    dec.t_ap    = instr[7];
    dec.t_an    = instr[8];
    dec.t_oc    = instr[9];
    dec.t_ip    = instr[10];
    dec.sw_code = instr[2*SEL_W-1:SEL_W];
    dec.fl_code = instr[SEL_W-1:0];
  end
endmodule

// File: rtl/skp_field_test.sv
module skp_field_test #(
  parameter int NLINE = 6,
  parameter int CW    = 3
) (
  input  logic [CW-1:0]    code,
  input  logic [NLINE-1:0] lines,
  output logic             hit
);
  localparam logic [CW-1:0] ALL_CODE = {CW{1'b1}};

  logic [NLINE-1:0] one_hit;

  for (genvar i = 0; i < NLINE; i++) begin : g_line
    localparam logic [CW-1:0] MY_CODE = CW'(i + 1);
    assign one_hit[i] = (code == MY_CODE) && !lines[i];
  end

  assign hit = (|one_hit) || ((code == ALL_CODE) && (lines == '0));
endmodule

// File: rtl/skp_out_reg.sv
module skp_out_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic skip_d,
  input  logic clr_d,
  output logic skip_q,
  output logic clr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      skip_q <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      skip_q <= skip_d;
      clr_q  <= clr_d;
    end
  end
endmodule

// File: rtl/skip_eval.sv
module skip_eval
  import skp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] acc,
  input  logic [WORD_W-1:0] ioreg,
  input  logic              ovf,
  input  logic [NSEL-1:0]   sense_sw,
  input  logic [NSEL-1:0]   flags,
  output logic              skip,
  output logic              ovf_clr
);
  skp_dec_t dec;
  logic     sw_hit, fl_hit;
  logic     grp_hit;   // strobed word of the skip group
  logic     any_hit;   // OR of all enabled tests
  logic     skip_d, clr_d;

  skp_decode u_dec (.instr(instr), .dec(dec));

  skp_field_test #(.NLINE(NSEL), .CW(SEL_W)) u_sw (
    .code(dec.sw_code), .lines(sense_sw), .hit(sw_hit));

  skp_field_test #(.NLINE(NSEL), .CW(SEL_W)) u_fl (
    .code(dec.fl_code), .lines(flags), .hit(fl_hit));

  assign grp_hit = strobe && dec.grp;

  always_comb begin
    any_hit = (dec.t_az && word_is_zero(acc))
           || (dec.t_ap && !word_sign(acc))
           || (dec.t_an &&  word_sign(acc))
           || (dec.t_oc && !ovf)
           || (dec.t_ip && !word_sign(ioreg))
           || sw_hit || fl_hit;
    skip_d  = grp_hit && (any_hit ^ dec.inv);
    clr_d   = grp_hit && dec.t_oc;
  end

  skp_out_reg u_reg (
    .clk(clk), .rst_n(rst_n), .skip_d(skip_d), .clr_d(clr_d),
    .skip_q(skip), .clr_q(ovf_clr));
endmodule

// File: rtl/skip_eval_chk.sv
module skip_eval_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        strobe,
  input logic [17:0] instr,
  input logic [17:0] acc,
  input logic        skip,
  input logic        ovf_clr,
  input logic        grp_hit
);
  // R12
  skip_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (skip || ovf_clr) |-> $past(strobe));

  // R2
  non_group_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && instr[17:13] != 5'b11010) |=> (!skip && !ovf_clr));

  // R11
  ovf_clear_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_hit && instr[9]) |=> ovf_clr);

  // R10
  empty_inverted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && instr[17:12] == 6'o65 && instr[11:0] == 12'o0) |=> skip);

  // R3
  ac_zero_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && instr[17:12] == 6'o64 && instr[11:0] == 12'o0100 && acc == '0)
      |=> skip);
endmodule

bind skip_eval skip_eval_chk u_chk (
  .clk(clk), .rst_n(rst_n), .strobe(strobe), .instr(instr), .acc(acc),
  .skip(skip), .ovf_clr(ovf_clr), .grp_hit(grp_hit));

// File: tb/sim_skip_eval.sv
module sim_skip_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 1'b0;
  logic [17:0] instr = '0, acc = '0, ioreg = '0;
  logic        ovf = 1'b0;
  logic [5:0]  sense_sw = '0, flags = '0;
  logic        skip, ovf_clr;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  skip_eval u0 (.clk(clk), .rst_n(rst_n), .strobe(strobe), .instr(instr),
    .acc(acc), .ioreg(ioreg), .ovf(ovf), .sense_sw(sense_sw), .flags(flags),
    .skip(skip), .ovf_clr(ovf_clr));

  function automatic bit sel_ok(input int code, input logic [5:0] l);
    if (code == 0) return 0;
    if (code == 7) return (l == 6'd0);
    return (l[code-1] == 1'b0);
  endfunction

  function automatic bit exp_skip(input logic [17:0] w, input logic [17:0] a,
      input logic [17:0] io, input logic o, input logic [5:0] sw,
      input logic [5:0] fl);
    int  op = int'(w >> 12);
    bit  c = 0;
    if (op != 'o64 && op != 'o65) return 0;
    if ((w & 18'o0100) != 0 && a == 18'd0) c = 1;
    if ((w & 18'o0200) != 0 && a < 18'o400000) c = 1;
    if ((w & 18'o0400) != 0 && a >= 18'o400000) c = 1;
    if ((w & 18'o1000) != 0 && o == 1'b0) c = 1;
    if ((w & 18'o2000) != 0 && io < 18'o400000) c = 1;
    if (sel_ok(int'((w >> 3) & 7), sw)) c = 1;
    if (sel_ok(int'(w & 7), fl)) c = 1;
    return (op == 'o65) ? !c : c;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s instr=%o acc=%o: got %b expected %b", req, instr, acc,
               act, exp);
    end
  endtask

  task automatic eval(input string req, input logic [17:0] w,
      input logic [17:0] a, input logic [17:0] io, input logic o,
      input logic [5:0] sw, input logic [5:0] fl, input bit stb);
    bit es, ec;
    int op;
    @(negedge clk);
    instr = w; acc = a; ioreg = io; ovf = o; sense_sw = sw; flags = fl;
    strobe = stb;
    op = int'(w >> 12);
    es = stb && exp_skip(w, a, io, o, sw, fl);
    ec = stb && (op == 'o64 || op == 'o65) && ((w & 18'o1000) != 0);
    @(negedge clk);
    strobe = 1'b0;
    check(req, skip, es);
    check({req, "/R11"}, ovf_clr, ec);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [17:0] acv [5] = '{18'o0, 18'o1, 18'o777777, 18'o400000, 18'o377777};
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", skip, 1'b0);
    check("R1", ovf_clr, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", skip, 1'b0);
    check("R1", ovf_clr, 1'b0);

    // R3 R4 R5 R6 R9 R10: all mask combinations, both opcodes
    for (int op = 'o64; op <= 'o65; op++)
      for (int m = 0; m < 64; m++)
        for (int ai = 0; ai < 5; ai++)
          for (int ii = 0; ii < 2; ii++)
            for (int o = 0; o < 2; o++)
              eval("R3/R4/R5/R6/R9/R10",
                   18'((op << 12) | (m << 6)), acv[ai],
                   (ii != 0) ? 18'o400000 : 18'o000123, o[0],
                   6'o77, 6'o77, 1'b1);

    // R7 sense field, R8 flag field, against every line pattern
    for (int inv = 0; inv < 2; inv++)
      for (int code = 0; code < 8; code++)
        for (int p = 0; p < 64; p++) begin
          eval("R7", 18'(((8'o64 + inv) << 12) | (code << 3)), 18'o1, 18'o0,
               1'b1, 6'(p), 6'o77, 1'b1);
          eval("R8", 18'(((8'o64 + inv) << 12) | code), 18'o1, 18'o0,
               1'b1, 6'o77, 6'(p), 1'b1);
        end

    // R9 sense and flag fields combined with mask tests
    eval("R9", 18'o640102, 18'o5, 18'o0, 1'b0, 6'o77, 6'o75, 1'b1);
    eval("R9", 18'o650170, 18'o5, 18'o0, 1'b0, 6'o01, 6'o77, 1'b1);

    // R2 other opcodes and missing strobe
    for (int op = 0; op < 64; op++)
      eval("R2", 18'((op << 12) | 'o7777), 18'o0, 18'o0, 1'b0, 6'o0, 6'o0, 1'b1);
    eval("R2", 18'o651000, 18'o0, 18'o0, 1'b0, 6'o0, 6'o0, 1'b0);
    eval("R2", 18'o640100, 18'o0, 18'o0, 1'b0, 6'o0, 6'o0, 1'b0);

    // R6 bit 11 alone has no effect
    eval("R6", 18'o644000, 18'o0, 18'o0, 1'b0, 6'o77, 6'o77, 1'b1);
    eval("R6", 18'o654000, 18'o0, 18'o0, 1'b0, 6'o77, 6'o77, 1'b1);

    // R12 back-to-back strobes, then a single pulse that must drop
    @(negedge clk);
    instr = 18'o650000; strobe = 1'b1;
    @(negedge clk);
    check("R12", skip, 1'b1);
    instr = 18'o641000; ovf = 1'b0;
    @(negedge clk);
    strobe = 1'b0;
    check("R12", skip, 1'b1);
    check("R12", ovf_clr, 1'b1);
    @(negedge clk);
    check("R12", skip, 1'b0);
    check("R12", ovf_clr, 1'b0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule